// File: doc/BRIEF.md
# Line Alarm Status with Simulation

This block gathers the line alarms of one E1 receive channel and turns them into register-level information for a host processor. It watches three conditions: loss of signal, alarm indication signal and code violation strobes. Two live status bits follow loss of signal and alarm indication. A three-bit interrupt status register latches each alarm event. A 16-bit code violation counter records errors. The host reads the interrupt status register or the counter through a simple read port, and each read clears what it returned. An interrupt request is raised for every latched event whose mask bit is set.

A simulation enable lets software test its alarm handling without a faulty line. While it is set, the real alarm inputs are ignored. Loss of signal and alarm indication are forced active, and one synthetic code violation is produced on each clock enable tick. Counting and interrupt latching go on as normal. When simulation is switched off, the forced conditions drop away. Any events they latched stay pending until the host reads them.

Top module: `line_alarm_stat`

## Requirements
- R1: After reset the status bits, the interrupt status register, the counter, the mask and irq are all zero.
- R2: los_stat and ais_stat show the effective loss of signal and alarm indication condition one cycle after it is applied, and return to 0 by themselves one cycle after the condition goes away.
- R3: While sim_en is 1, the los_in, ais_in and cv_in inputs have no effect: both status bits read 1, and cv_in does not change the counter.
- R4: While sim_en is 1, each cycle with tick high adds one code violation to the counter. Cycles with tick low add none.
- R5: The code violation counter is 16 bits wide, counts each effective violation, and holds at 0xFFFF instead of wrapping.
- R6: Interrupt status bit 0 (loss of signal) and bit 1 (alarm indication) are set on a rising edge of their effective condition. Bit 2 is set by every effective code violation. A set bit stays set while its condition remains or goes away, until it is read.
- R7: With rd_sel=0, rd_data carries the interrupt status in bits 2:0 with zeros above. With rd_sel=1, rd_data carries the counter. A cycle with rd_en high clears the selected register at the clock edge that ends it.
- R8: When a set event and a read clear hit the same register in the same cycle, the event wins. The status bit stays 1, and the counter restarts at 1.
- R9: mask_wdata is loaded into the 3-bit mask on a cycle with mask_wr high. irq is 1 exactly when a status bit and its mask bit are both 1.
- R10: When sim_en falls, both status bits drop on the following cycle. Interrupt bits raised during simulation stay pending until read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable tick that paces synthetic violations |
| los_in | input | 1 | Real loss of signal condition |
| ais_in | input | 1 | Real alarm indication condition |
| cv_in | input | 1 | Real code violation strobe, one per violation |
| sim_en | input | 1 | Alarm simulation enable |
| mask_wr | input | 1 | Load strobe for the interrupt mask |
| mask_wdata | input | 3 | New interrupt mask value |
| rd_en | input | 1 | Read strobe; clears the selected register |
| rd_sel | input | 1 | 0 selects the interrupt status, 1 the counter |
| rd_data | output | 16 | Read data of the selected register |
| los_stat | output | 1 | Live loss of signal status |
| ais_stat | output | 1 | Live alarm indication status |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets the collisions between a read clear and a new event on both the status register and the counter. A design that let the clear win would silently lose an alarm, or restart the counter at zero. It holds alarm indication high across a read to confirm that a level condition does not re-latch without a fresh rising edge. It also checks that events raised in simulation survive the end of simulation. The counter is driven past 65535 synthetic ticks, so a wrapping counter would read a small value instead of 0xFFFF. All eight mask values are swept against a full status register to catch a wrong bit pairing in the interrupt request.

// File: rtl/line_alarm_stat.sv
module line_alarm_stat #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             los_in,
  input  logic             ais_in,
  input  logic             cv_in,
  input  logic             sim_en,
  input  logic             mask_wr,
  input  logic [2:0]       mask_wdata,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             los_stat,
  output logic             ais_stat,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]       isr_q, mask_q, isr_set;
  logic [CNT_W-1:0] cnt_q;
  logic             los_eff, ais_eff, cv_eff, isr_clr, cnt_clr;

  assign los_eff = sim_en | los_in;
  assign ais_eff = sim_en | ais_in;
  assign cv_eff  = sim_en ? tick : cv_in;
  assign isr_clr = rd_en & ~rd_sel;
  assign cnt_clr = rd_en & rd_sel;
  assign isr_set = {cv_eff, ais_eff & ~ais_stat, los_eff & ~los_stat};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los_stat <= 1'b0;
      ais_stat <= 1'b0;
    end else begin
      los_stat <= los_eff;
      ais_stat <= ais_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      isr_q <= '0;
    else
      isr_q <= (isr_clr ? 3'b000 : isr_q) | isr_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_clr)
      cnt_q <= cv_eff ? CNT_W'(1) : '0;
    else if (cv_eff && cnt_q != CNT_MAX)
      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '0;
    else if (mask_wr)
      mask_q <= mask_wdata;
  end

  assign irq     = |(isr_q & mask_q);
  assign rd_data = rd_sel ? cnt_q : {{(CNT_W-3){1'b0}}, isr_q};

  p_sim_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sim_en |=> (los_stat && ais_stat));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && rd_data == CNT_MAX && !rd_en) |=> (cnt_q == CNT_MAX));
  p_sim_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sim_en && tick && !cnt_clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q[0] && !isr_clr) |=> isr_q[0]);
  p_latch_los_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_stat) |-> isr_q[0]);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr && cv_eff) |=> isr_q[2]);
endmodule

// File: tb/line_alarm_stat_tb.sv
module line_alarm_stat_tb;
  logic clk = 0, rst_n = 0, tick = 0, los_in = 0, ais_in = 0, cv_in = 0, sim_en = 0;
  logic mask_wr = 0, rd_en = 0, rd_sel = 0;
  logic [2:0] mask_wdata = 0;
  logic [15:0] rd_data;
  logic los_stat, ais_stat, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  line_alarm_stat u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .los_in(los_in),
    .ais_in(ais_in), .cv_in(cv_in), .sim_en(sim_en), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .los_stat(los_stat), .ais_stat(ais_stat), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(logic sel, output logic [15:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic rd_clear(logic sel);
    rd_sel = sel; rd_en = 1; step(); rd_en = 0;
  endtask

  logic [15:0] v;

  initial begin
    step(2); rst_n = 1; step();
    peek(0, v); chk("R1 isr", v, 0);
    peek(1, v); chk("R1 cnt", v, 0);
    chk("R1 stat", {los_stat, ais_stat, irq}, 0);

    los_in = 1; step();
    chk("R2 los up", los_stat, 1);
    peek(0, v); chk("R6 los latch", v, 1);
    los_in = 0; step();
    chk("R2 los auto clear", los_stat, 0);
    peek(0, v); chk("R6 stays", v, 1);
    rd_clear(0);
    peek(0, v); chk("R7 isr cleared", v, 0);

    ais_in = 1; step(); chk("R2 ais up", ais_stat, 1);
    rd_clear(0);
    peek(0, v); chk("R6 no relatch while level", v, 0);
    ais_in = 0; step();

    cv_in = 1; step(5); cv_in = 0;
    peek(1, v); chk("R5 cnt 5", v, 5);
    peek(0, v); chk("R6 cv flag", v, 4);
    rd_clear(1);
    peek(1, v); chk("R7 cnt cleared", v, 0);

    chk("R9 masked off", irq, 0);
    mask_wdata = 3'b100; mask_wr = 1; step(); mask_wr = 0;
    chk("R9 irq cv", irq, 1);

    cv_in = 1; rd_sel = 0; rd_en = 1; step(); rd_en = 0; cv_in = 0;
    peek(0, v); chk("R8 isr set wins", v, 4);
    cv_in = 1; rd_sel = 1; rd_en = 1; step(); rd_en = 0; cv_in = 0;
    peek(1, v); chk("R8 cnt restarts", v, 1);
    rd_clear(1); rd_clear(0);

    sim_en = 1; cv_in = 1; los_in = 0; ais_in = 0; step();
    chk("R3 sim status", {los_stat, ais_stat}, 2'b11);
    peek(1, v); chk("R3 cv_in ignored", v, 0);
    peek(0, v); chk("R6 sim alarms latched", v, 3);
    cv_in = 0; tick = 1; step(7); tick = 0;
    peek(1, v); chk("R4 sim ticks", v, 7);
    step(2); peek(1, v); chk("R4 no tick no count", v, 7);
    sim_en = 0; step();
    chk("R10 status drop", {los_stat, ais_stat}, 0);
    peek(0, v); chk("R10 pending", v, 7);

    for (int m = 0; m < 8; m++) begin
      mask_wdata = 3'(m); mask_wr = 1; step(); mask_wr = 0;
      chk("R9 mask sweep", irq, (m != 0));
    end
    rd_clear(0); rd_clear(1);

    sim_en = 1; tick = 1; step(65540);
    peek(1, v); chk("R5 saturate", v, 16'hFFFF);
    rd_sel = 1; rd_en = 1; step(); rd_en = 0; tick = 0;
    peek(1, v); chk("R8 sat read collide", v, 1);
    sim_en = 0; step();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule